// File: doc/BRIEF.md
# Stop-Clock Power State Controller

This block sits beside a processor-like core and moves it in and out of a low-power clock-stopped state. A stop request arrives on an active-low pin that is asynchronous to the block clock. The request is first passed through a flop synchroniser. On a synchronised request the block asks a bus transaction issuer, over a valid/ready handshake, to send one grant acknowledge onto the bus. Once the issuer accepts that request, the block withdraws the clock enables of every core unit. The only exceptions are the bus interface unit and the interrupt controller unit, which stay enabled so that snooping and interrupt service carry on.

When the request pin goes back high, every unit enable returns and execution resumes. A request that is withdrawn while the acknowledge is still waiting does not cancel it. The acknowledge completes, and the block then goes straight back to running without gating anything. The current state is brought out as a two-bit code. The block drives enables only; the gating cells, the PLL and the bus encoding live elsewhere. The bus clock is not touched.

Top module: `stopclk_ctrl`

## Requirements
- R1: While reset is held low and right after it is released, `pm_state` reads 2'd0 (running), `ack_valid` is 0 and every bit of `unit_clk_en` is 1.
- R2: With the default two synchroniser stages, a low level on `stop_req_n` leaves `pm_state` at running for the first two rising clock edges and moves it to 2'd1 (acknowledge pending) on the third.
- R3: `ack_valid` is 1 exactly while `pm_state` is 2'd1 and stays 1 until a cycle with `ack_ready` high. Each entry attempt produces exactly one accepted acknowledge (a cycle with both signals high).
- R4: While `pm_state` is 2'd0 or 2'd1, every bit of `unit_clk_en` is 1, so no core unit is gated before the acknowledge is accepted.
- R5: An accepted acknowledge while the synchronised request is still active moves `pm_state` to 2'd2 (stop-grant) on that edge. In 2'd2, `unit_clk_en` has only bit `BUS_UNIT` and bit `IRQ_UNIT` set (bits 0 and 1 by default).
- R6: `unit_clk_en[BUS_UNIT]` and `unit_clk_en[IRQ_UNIT]` are 1 in every state.
- R7: When `stop_req_n` returns high during stop-grant, `pm_state` stays at 2'd2 for two rising edges and returns to 2'd0 on the third, with every enable set again.
- R8: If the synchronised request is withdrawn while in 2'd1, `ack_valid` stays 1 until accepted. The accepting edge then moves `pm_state` directly to 2'd0, never passing through 2'd2.
- R9: `ack_ready` has no effect on `pm_state`, `ack_valid` or `unit_clk_en` in states 2'd0 and 2'd2.
- R10: An asynchronous reset asserted in any state returns the block at once to the R1 values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req_n | input | 1 | Asynchronous active-low stop request |
| ack_ready | input | 1 | Bus issuer accepts the acknowledge request |
| ack_valid | output | 1 | Request to issue one grant acknowledge transaction |
| unit_clk_en | output | NUM_UNITS | Per-unit clock enables, 1 = clocked |
| pm_state | output | 2 | 0 running, 1 acknowledge pending, 2 stop-grant |

## Verification
The main function is driven through three request patterns. A full entry-and-exit sequence shows the synchroniser latency in both directions and the point at which gating begins. A short pulse withdrawn before the issuer accepts separates the abort path from a real entry. A ready signal held high in running and stop-grant shows that a spurious accept cannot move the state or end the gating. Two directed cases follow: a stall of several cycles with ready low, which tests that valid is held, and a reset pulse taken in stop-grant.

// File: rtl/stopclk_pkg.sv
package stopclk_pkg;
   typedef enum logic [1:0] {
      PST_RUN   = 2'd0,
      PST_ACK   = 2'd1,
      PST_GRANT = 2'd2
   } pst_e;
endpackage

// File: rtl/pst_sync.sv
module pst_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pst_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= RESET_VAL;
      else        chain[0] <= d_async;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= RESET_VAL;
         else        chain[s] <= chain[s-1];
      end
   end

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/pst_fsm.sv
module pst_fsm
   import stopclk_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_active,
   input  logic ack_ready,
   output logic ack_valid,
   output pst_e state
);
   pst_e state_nx;
   logic accept;

   assign ack_valid = (state == PST_ACK);
   assign accept    = ack_valid && ack_ready;

   always_comb begin
      state_nx = state;
      unique case (state)
         PST_RUN:   if (req_active) state_nx = PST_ACK;
         PST_ACK:   if (accept) state_nx = req_active ? PST_GRANT : PST_RUN;
         PST_GRANT: if (!req_active) state_nx = PST_RUN;
         default:   state_nx = PST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= PST_RUN;
      else        state <= state_nx;
   end

   assert_valid_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && !ack_ready) |=> ack_valid);
   assert_grant_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && ack_ready && req_active) |=> (state == PST_GRANT));
   assert_abort_direct_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && ack_ready && !req_active) |=> (state == PST_RUN));
   assert_no_skip_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PST_RUN) |=> (state != PST_GRANT));
   assert_ready_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PST_GRANT && req_active) |=> (state == PST_GRANT));
endmodule

// File: rtl/pst_gate.sv
module pst_gate
   import stopclk_pkg::*;
#(
   parameter int NUM_UNITS = 6,
   parameter int BUS_UNIT  = 0,
   parameter int IRQ_UNIT  = 1,
   parameter bit REG_OUT   = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  pst_e                 state,
   output logic [NUM_UNITS-1:0] unit_en
);
   localparam logic [NUM_UNITS-1:0] KEEP_MASK =
      (NUM_UNITS'(1) << BUS_UNIT) | (NUM_UNITS'(1) << IRQ_UNIT);

   if (NUM_UNITS < 2 || BUS_UNIT >= NUM_UNITS || IRQ_UNIT >= NUM_UNITS
       || BUS_UNIT == IRQ_UNIT) begin : g_bad_units
      $error("pst_gate: unit indices out of range or equal");
   end

   logic                 gated;
   logic [NUM_UNITS-1:0] en_raw;

   assign gated = (state == PST_GRANT);

   for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
      if (KEEP_MASK[u]) begin : g_keep
         assign en_raw[u] = 1'b1;
      end else begin : g_core
         assign en_raw[u] = !gated;
      end
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) unit_en <= '1;
         else        unit_en <= en_raw;
      end
   end else begin : g_comb
      assign unit_en = en_raw;
   end

   if (!REG_OUT) begin : g_chk
      assert_ungated_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (state != PST_GRANT) |-> (&unit_en));
      assert_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (state == PST_GRANT) |-> (unit_en == KEEP_MASK));
   end
   assert_keep_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
      unit_en[BUS_UNIT] && unit_en[IRQ_UNIT]);
endmodule

// File: rtl/stopclk_ctrl.sv
module stopclk_ctrl
   import stopclk_pkg::*;
#(
   parameter int NUM_UNITS   = 6,
   parameter int BUS_UNIT    = 0,
   parameter int IRQ_UNIT    = 1,
   parameter int SYNC_STAGES = 2,
   parameter bit REG_EN_OUT  = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 stop_req_n,
   input  logic                 ack_ready,
   output logic                 ack_valid,
   output logic [NUM_UNITS-1:0] unit_clk_en,
   output logic [1:0]           pm_state
);
   logic req_n_sync;
   logic req_active;
   pst_e state;

   pst_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (stop_req_n),
      .q_sync  (req_n_sync)
   );

   assign req_active = !req_n_sync;

   pst_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_active (req_active),
      .ack_ready  (ack_ready),
      .ack_valid  (ack_valid),
      .state      (state)
   );

   pst_gate #(
      .NUM_UNITS (NUM_UNITS),
      .BUS_UNIT  (BUS_UNIT),
      .IRQ_UNIT  (IRQ_UNIT),
      .REG_OUT   (REG_EN_OUT)
   ) u_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .state   (state),
      .unit_en (unit_clk_en)
   );

   assign pm_state = state;

   assert_valid_only_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid == (pm_state == 2'd1));
endmodule

// File: tb/stopclk_ctrl_tb.sv
module stopclk_ctrl_tb;
   localparam int NU  = 6;
   localparam int BUS = 0;
   localparam int IRQ = 1;
   localparam logic [NU-1:0] KEEP = (NU'(1) << BUS) | (NU'(1) << IRQ);
   localparam logic [NU-1:0] ALL  = '1;

   // row: {stop_req_n, ack_ready, state[1:0], ack_valid, gated}
   localparam int NV = 17;
   localparam logic [5:0] VEC [0:NV-1] = '{
      6'b00_00_0_0, 6'b00_00_0_0, 6'b00_01_1_0, 6'b00_01_1_0,
      6'b01_10_0_1, 6'b01_10_0_1, 6'b10_10_0_1, 6'b10_10_0_1,
      6'b10_00_0_0, 6'b00_00_0_0, 6'b00_00_0_0, 6'b10_01_1_0,
      6'b10_01_1_0, 6'b10_01_1_0, 6'b11_00_0_0, 6'b10_00_0_0,
      6'b11_00_0_0
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic stop_req_n = 1'b1;
   logic ack_ready = 1'b0;
   logic ack_valid;
   logic [NU-1:0] unit_clk_en;
   logic [1:0] pm_state;

   int n_chk = 0;
   int n_bad = 0;
   int n_acc = 0;

   always #5 clk = ~clk;

   stopclk_ctrl #(.NUM_UNITS(NU), .BUS_UNIT(BUS), .IRQ_UNIT(IRQ)) u_dut (
      .clk(clk), .rst_n(rst_n), .stop_req_n(stop_req_n), .ack_ready(ack_ready),
      .ack_valid(ack_valid), .unit_clk_en(unit_clk_en), .pm_state(pm_state)
   );

   always @(posedge clk) if (rst_n && ack_valid && ack_ready) n_acc++;

   task automatic check(string tag, logic [1:0] st, logic v, logic [NU-1:0] en);
      n_chk++;
      if (pm_state !== st || ack_valid !== v || unit_clk_en !== en) begin
         n_bad++;
         $display("FAIL %s: got state=%0d valid=%0b en=%b, expected state=%0d valid=%0b en=%b",
                  tag, pm_state, ack_valid, unit_clk_en, st, v, en);
      end
   endtask

   function automatic string row_tag(int i);
      case (i)
         0, 1, 2:     return "R2 entry latency";
         3:           return "R3 R4 valid held, enables on";
         4:           return "R5 R6 grant entry";
         5:           return "R9 ready ignored in grant";
         6, 7, 8:     return "R7 exit latency";
         9, 10, 11:   return "R2 second entry";
         12, 13:      return "R8 ack held after withdraw";
         14:          return "R8 direct return";
         default:     return "R9 ready ignored in run";
      endcase
   endfunction

   initial begin : watchdog
      #100000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (2) @(posedge clk);
      #1 check("R1 in reset", 2'd0, 1'b0, ALL);
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk);
      #1 check("R1 after reset", 2'd0, 1'b0, ALL);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         stop_req_n = VEC[i][5];
         ack_ready  = VEC[i][4];
         @(posedge clk);
         #1 check(row_tag(i), VEC[i][3:2], VEC[i][1], VEC[i][0] ? KEEP : ALL);
      end
      @(negedge clk) ack_ready = 1'b0;
      n_chk++;
      if (n_acc != 2) begin
         n_bad++;
         $display("FAIL R3 one accept per entry: got %0d, expected 2", n_acc);
      end

      // R3: long stall keeps valid high
      stop_req_n = 1'b0;
      repeat (3) @(posedge clk);
      repeat (6) @(posedge clk);
      #1 check("R3 long stall", 2'd1, 1'b1, ALL);
      @(negedge clk) ack_ready = 1'b1;
      @(posedge clk);
      #1 check("R5 accept after stall", 2'd2, 1'b0, KEEP);
      @(negedge clk) ack_ready = 1'b0;

      // R10: reset in stop-grant
      #2 rst_n = 1'b0;
      #1 check("R10 async reset in grant", 2'd0, 1'b0, ALL);
      @(negedge clk) begin
         stop_req_n = 1'b1;
         rst_n = 1'b1;
      end
      repeat (4) @(posedge clk);
      #1 check("R10 stays running", 2'd0, 1'b0, ALL);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule